// File: doc/BRIEF.md
# Write-Through Data Cache Controller

This block sits between a processor's data port and a shared bus server. It holds a small direct-mapped cache of 8 lines, each four 32-bit words (128 bytes in all). Reads that hit are answered in the cycle they are presented. Reads that miss make the bus server fetch the whole line, which is then installed. Reads of uncached addresses fetch a single word and allocate nothing. A bus error on any read is returned to the processor as an error.

Every store goes to memory through a four-entry posted write FIFO, which the bus server drains. A store never allocates a line. When a store hits, the cached word is patched in its enabled byte lanes only. The processor stalls only on a read miss, an uncached read, or a full write FIFO.

A read that needs the bus waits until the FIFO is empty, so a refill can never return data older than a posted store. The store-posting state accepts the next request exactly as the idle state does, so a burst of stores enters the FIFO at one per cycle. It holds back a new store only when the push it is making in that cycle would leave no free slot.

Top module: `wt_dcache_ctrl`

States (type `dc_state_e`) and their transitions:
- `ST_IDLE` and `ST_POST` both dispatch a request:
  - no request goes to `ST_IDLE`;
  - a store with room goes to `ST_HIT_UPD` on a hit, otherwise to `ST_POST`;
  - a store without room goes to `ST_IDLE`;
  - an uncached read goes to `ST_UNC_WAIT`;
  - a read hit goes to `ST_IDLE`;
  - a read miss goes to `ST_SELECT`.
- `ST_POST` also pushes the latched store in the same cycle.
- `ST_HIT_UPD` patches the cached word and goes to `ST_POST`.
- `ST_SELECT` picks the victim line and goes to `ST_REFILL` once the FIFO is empty.
- `ST_REFILL`, on `rsp_done`, goes to `ST_INSTALL`, or to `ST_FAULT` on an error.
- `ST_INSTALL` writes the line and goes to `ST_IDLE`.
- `ST_UNC_WAIT`, on `rsp_done`, goes to `ST_UNC_GO`, or to `ST_FAULT` on an error.
- `ST_UNC_GO` and `ST_FAULT` answer the processor and go to `ST_IDLE`.

## Requirements
- R1: After reset all lines are invalid, `rd_req` and `wb_rok` are low, and `cpu_ready` stays low while no request is presented.
- R2: The address splits into byte-in-line bits [3:0] (word select [3:2]), line index [6:4] and tag [31:7]. A cached read that hits has `cpu_ready` high with the word in the first cycle it is presented, and makes no bus request.
- R3: A cached read that misses holds `rd_req` high with `rd_line`=1 and `rd_addr` aligned to 16 bytes until `rsp_done`. It takes four `rsp_word` beats as words 0..3 and then returns the requested word. `cpu_ready` is low while `rd_req` is high, and later reads of that line hit.
- R4: A read that maps to the same index with a different tag replaces the line, so going back to the old tag misses again.
- R5: A read with `cpu_unc`=1 issues a single-word request (`rd_line`=0, `rd_addr` word-aligned) and returns that word. It never allocates, so repeating it goes to the bus again.
- R6: A bus error on a read (`rsp_err` with `rsp_done`) answers the processor with `cpu_ready` and `cpu_err` high together and installs nothing.
- R7: Every accepted store appears on the FIFO read side in acceptance order, with its address, data and byte enables. A store miss allocates no line.
- R8: A store that hits updates only the enabled byte lanes of the cached word. A following read returns the merged word without a refill.
- R9: With the FIFO empty and never popped, four stores are accepted in four consecutive cycles. A fifth waits until a pop, and the FIFO never overflows.
- R10: `rd_req` is never high while `wb_rok` is high. A read that needs the bus waits for the FIFO to drain.
- R11: `wb_rok` is high exactly when the FIFO holds entries. `wb_pop` with `wb_rok` removes the head entry, and a push makes `wb_rok` high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor presents a request, held until accepted |
| cpu_wr | input | 1 | Request is a store |
| cpu_unc | input | 1 | Address lies in an uncached region |
| cpu_addr | input | 32 | Byte address |
| cpu_be | input | 4 | Store byte enables |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Request accepted or answered this cycle |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| cpu_err | output | 1 | Read ended in a bus error |
| rd_req | output | 1 | Read transaction requested from the bus server |
| rd_line | output | 1 | 1 = full-line fetch, 0 = single word |
| rd_addr | output | 32 | Aligned fetch address |
| rsp_word | input | 1 | One fetched word is on rsp_data |
| rsp_data | input | 32 | Fetched word |
| rsp_done | input | 1 | Read transaction finished |
| rsp_err | input | 1 | Transaction ended in error, valid with rsp_done |
| wb_rok | output | 1 | Write FIFO holds at least one entry |
| wb_addr | output | 32 | Head entry address |
| wb_data | output | 32 | Head entry data |
| wb_be | output | 4 | Head entry byte enables |
| wb_pop | input | 1 | Bus server takes the head entry |

## Verification
The bound checker watches, every cycle, that:
- no read request is raised while posted stores remain;
- no push lands in a full FIFO;
- a push always makes the FIFO non-empty;
- the processor is stalled during a fetch;
- errors come only with a response;
- a pending fetch address stays steady.

The bench shows what only sequences can reveal. Hits cost no cycles. Conflict and uncached reads return to the bus. A patched byte lane survives without a refill. Four stores stream in on consecutive cycles while a fifth waits. Finally, the drained store stream matches the accepted stores in order and content under randomly timed pops.

// File: rtl/dc_pkg.sv
package dc_pkg;
    localparam int unsigned AW = 32;
    localparam int unsigned DW = 32;
    localparam int unsigned BW = DW / 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_POST,
        ST_HIT_UPD,
        ST_SELECT,
        ST_REFILL,
        ST_INSTALL,
        ST_UNC_WAIT,
        ST_UNC_GO,
        ST_FAULT
    } dc_state_e;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [BW-1:0] be;
    } wb_entry_t;
endpackage

// File: rtl/dc_wbuf.sv
module dc_wbuf
    import dc_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  wb_entry_t push_e,
    input  logic      pop,
    output wb_entry_t head,
    output logic [CW-1:0] count
);
    wb_entry_t slot_q [DEPTH];
    logic [PW-1:0] wr_ptr_q, rd_ptr_q;
    logic pop_ok;

    assign pop_ok = pop && (count != '0);
    assign head   = slot_q[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (push) slot_q[wr_ptr_q] <= push_e;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count    <= '0;
        end else begin
            if (push)
                wr_ptr_q <= (int'(wr_ptr_q) == DEPTH - 1) ? '0 : wr_ptr_q + 1'b1;
            if (pop_ok)
                rd_ptr_q <= (int'(rd_ptr_q) == DEPTH - 1) ? '0 : rd_ptr_q + 1'b1;
            if (push && !pop_ok)      count <= count + 1'b1;
            else if (!push && pop_ok) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/dc_array.sv
module dc_array
    import dc_pkg::*;
#(
    parameter int unsigned NLINES = 8,
    parameter int unsigned LWORDS = 4,
    parameter int unsigned TAG_W  = 25,
    localparam int unsigned IDX_W  = $clog2(NLINES),
    localparam int unsigned WSEL_W = $clog2(LWORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WSEL_W-1:0] rd_wsel,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_word,
    input  logic              upd_en,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic [WSEL_W-1:0] upd_wsel,
    input  logic [DW-1:0]     upd_data,
    input  logic [BW-1:0]     upd_be,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [LWORDS-1:0][DW-1:0] fill_line
);
    logic [DW-1:0]    data_q [NLINES][LWORDS];
    logic [TAG_W-1:0] tag_q  [NLINES];
    logic [NLINES-1:0] valid_q;

    assign rd_tag   = tag_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];
    assign rd_word  = data_q[rd_idx][rd_wsel];

    always_ff @(posedge clk) begin
        if (!rst_n)       valid_q <= '0;
        else if (fill_en) valid_q[fill_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_idx] <= fill_tag;
            for (int w = 0; w < LWORDS; w++)
                data_q[fill_idx][w] <= fill_line[w];
        end else if (upd_en) begin
            for (int b = 0; b < BW; b++)
                if (upd_be[b]) data_q[upd_idx][upd_wsel][8*b +: 8] <= upd_data[8*b +: 8];
        end
    end
endmodule

// File: rtl/wt_dcache_ctrl.sv
module wt_dcache_ctrl
    import dc_pkg::*;
#(
    parameter int unsigned NLINES   = 8,
    parameter int unsigned LWORDS   = 4,
    parameter int unsigned WB_DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_wr,
    input  logic          cpu_unc,
    input  logic [AW-1:0] cpu_addr,
    input  logic [BW-1:0] cpu_be,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_ready,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_err,
    output logic          rd_req,
    output logic          rd_line,
    output logic [AW-1:0] rd_addr,
    input  logic          rsp_word,
    input  logic [DW-1:0] rsp_data,
    input  logic          rsp_done,
    input  logic          rsp_err,
    output logic          wb_rok,
    output logic [AW-1:0] wb_addr,
    output logic [DW-1:0] wb_data,
    output logic [BW-1:0] wb_be,
    input  logic          wb_pop
);
    localparam int unsigned BSEL_W = $clog2(BW);
    localparam int unsigned WSEL_W = $clog2(LWORDS);
    localparam int unsigned OFF_W  = BSEL_W + WSEL_W;
    localparam int unsigned IDX_W  = $clog2(NLINES);
    localparam int unsigned TAG_W  = AW - IDX_W - OFF_W;
    localparam int unsigned CNT_W  = $clog2(WB_DEPTH + 1);
    localparam logic [AW-1:0] LINE_MASK = AW'(LWORDS * BW - 1);
    localparam logic [AW-1:0] WORD_MASK = AW'(BW - 1);

    dc_state_e state_q, state_d;
    wb_entry_t wr_q, wb_head;
    logic [AW-1:0] miss_addr_q;
    logic [LWORDS-1:0][DW-1:0] fill_q;
    logic [WSEL_W-1:0] beat_q;
    logic [DW-1:0] unc_q;
    logic [CNT_W-1:0] wb_cnt;
    logic [TAG_W-1:0] arr_tag;
    logic arr_valid, hit, wok, pop_fire;
    logic wb_push, take_wr, take_rd, upd_en, fill_en, sel_unc;
    logic [DW-1:0] arr_word;

    // FIFO read side toward the bus server
    assign wb_rok   = (wb_cnt != '0);
    assign pop_fire = wb_pop && wb_rok;
    assign wb_addr  = wb_head.addr;
    assign wb_data  = wb_head.data;
    assign wb_be    = wb_head.be;

    dc_wbuf #(.DEPTH(WB_DEPTH)) u_wbuf (
        .clk(clk), .rst_n(rst_n), .push(wb_push), .push_e(wr_q),
        .pop(wb_pop), .head(wb_head), .count(wb_cnt)
    );

    dc_array #(.NLINES(NLINES), .LWORDS(LWORDS), .TAG_W(TAG_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(cpu_addr[OFF_W +: IDX_W]), .rd_wsel(cpu_addr[BSEL_W +: WSEL_W]),
        .rd_tag(arr_tag), .rd_valid(arr_valid), .rd_word(arr_word),
        .upd_en(upd_en), .upd_idx(wr_q.addr[OFF_W +: IDX_W]),
        .upd_wsel(wr_q.addr[BSEL_W +: WSEL_W]), .upd_data(wr_q.data), .upd_be(wr_q.be),
        .fill_en(fill_en), .fill_idx(miss_addr_q[OFF_W +: IDX_W]),
        .fill_tag(miss_addr_q[AW-1 -: TAG_W]), .fill_line(fill_q)
    );

    assign hit = arr_valid && (arr_tag == cpu_addr[AW-1 -: TAG_W]) && !cpu_unc;

    // Room check: in ST_POST the slot being pushed this cycle is already taken
    always_comb begin
        if (state_q == ST_POST)
            wok = (int'(wb_cnt) - int'(pop_fire)) < int'(WB_DEPTH) - 1;
        else
            wok = int'(wb_cnt) < int'(WB_DEPTH);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        cpu_ready = 1'b0;
        cpu_err   = 1'b0;
        wb_push   = 1'b0;
        take_wr   = 1'b0;
        take_rd   = 1'b0;
        rd_req    = 1'b0;
        rd_line   = 1'b0;
        upd_en    = 1'b0;
        fill_en   = 1'b0;
        sel_unc   = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_POST: begin
                wb_push = (state_q == ST_POST);
                state_d = ST_IDLE;
                if (cpu_req) begin
                    if (cpu_wr) begin
                        if (wok) begin
                            cpu_ready = 1'b1;
                            take_wr   = 1'b1;
                            state_d   = hit ? ST_HIT_UPD : ST_POST;
                        end
                    end else if (cpu_unc) begin
                        take_rd = 1'b1;
                        state_d = ST_UNC_WAIT;
                    end else if (hit) begin
                        cpu_ready = 1'b1;
                    end else begin
                        take_rd = 1'b1;
                        state_d = ST_SELECT;
                    end
                end
            end
            ST_HIT_UPD: begin
                upd_en  = 1'b1;
                state_d = ST_POST;
            end
            ST_SELECT: begin
                if (!wb_rok) state_d = ST_REFILL;
            end
            ST_REFILL: begin
                rd_req  = 1'b1;
                rd_line = 1'b1;
                if (rsp_done) state_d = rsp_err ? ST_FAULT : ST_INSTALL;
            end
            ST_INSTALL: begin
                fill_en = 1'b1;
                state_d = ST_IDLE;
            end
            ST_UNC_WAIT: begin
                rd_req = !wb_rok;
                if (rsp_done) state_d = rsp_err ? ST_FAULT : ST_UNC_GO;
            end
            ST_UNC_GO: begin
                cpu_ready = 1'b1;
                sel_unc   = 1'b1;
                state_d   = ST_IDLE;
            end
            ST_FAULT: begin
                cpu_ready = 1'b1;
                cpu_err   = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign cpu_rdata = sel_unc ? unc_q : arr_word;
    assign rd_addr   = (state_q == ST_REFILL) ? (miss_addr_q & ~LINE_MASK)
                                              : (miss_addr_q & ~WORD_MASK);

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else begin
            if (take_wr) begin
                wr_q.addr <= cpu_addr;
                wr_q.data <= cpu_wdata;
                wr_q.be   <= cpu_be;
            end
            if (take_rd) begin
                miss_addr_q <= cpu_addr;
                beat_q      <= '0;
            end
            if (state_q == ST_REFILL && rsp_word) begin
                fill_q[beat_q] <= rsp_data;
                beat_q         <= beat_q + 1'b1;
            end
            if (state_q == ST_UNC_WAIT && rsp_word) unc_q <= rsp_data;
        end
    end
endmodule

// File: rtl/dc_chk.sv
module dc_chk #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned CNT_W = 3,
    parameter int unsigned AW    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_req,
    input logic [AW-1:0]    rd_addr,
    input logic             rsp_done,
    input logic             wb_rok,
    input logic             wb_push,
    input logic [CNT_W-1:0] wb_cnt,
    input logic             cpu_ready,
    input logic             cpu_err
);
    // R10
    drain_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !wb_rok);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_push |-> int'(wb_cnt) < int'(DEPTH));

    // R11
    push_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_push |=> wb_rok);

    // R6
    err_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_err |-> cpu_ready);

    // R3
    stall_in_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !cpu_ready);

    // R3
    fetch_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rsp_done) |=> (rd_req && $stable(rd_addr)));
endmodule

bind wt_dcache_ctrl dc_chk #(.DEPTH(WB_DEPTH), .CNT_W(CNT_W), .AW(AW)) u_dc_chk (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .rsp_done(rsp_done), .wb_rok(wb_rok), .wb_push(wb_push), .wb_cnt(wb_cnt),
    .cpu_ready(cpu_ready), .cpu_err(cpu_err)
);

// File: tb/test_wt_dcache_ctrl.sv
module test_wt_dcache_ctrl;
    import dc_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req = 1'b0, cpu_wr = 1'b0, cpu_unc = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic cpu_ready, cpu_err, rd_req, rd_line, wb_rok;
    logic [31:0] cpu_rdata, rd_addr, wb_addr, wb_data;
    logic [3:0]  wb_be;
    logic rsp_word = 1'b0, rsp_done = 1'b0, rsp_err = 1'b0, wb_pop = 1'b0;
    logic [31:0] rsp_data = '0;

    always #5 clk = ~clk;

    wt_dcache_ctrl i_wt_dcache_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_unc(cpu_unc),
        .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .cpu_err(cpu_err),
        .rd_req(rd_req), .rd_line(rd_line), .rd_addr(rd_addr),
        .rsp_word(rsp_word), .rsp_data(rsp_data), .rsp_done(rsp_done), .rsp_err(rsp_err),
        .wb_rok(wb_rok), .wb_addr(wb_addr), .wb_data(wb_data), .wb_be(wb_be), .wb_pop(wb_pop)
    );

    int n_tests = 0, n_fail = 0;
    int line_fetches = 0, word_fetches = 0, drain_viol = 0;
    bit pop_en = 1'b0;
    logic [31:0] last_fetch_addr;
    logic last_fetch_line;
    logic [31:0] bus_mem [logic [29:0]];
    logic [31:0] ref_mem [logic [29:0]];
    wb_entry_t exp_q [$];

    logic [31:0] r_data;
    bit r_err;
    int r_wait;

    function automatic logic [31:0] seed_word(logic [29:0] w);
        return (32'(w) * 32'h9E37_79B1) ^ 32'h1234_5678;
    endfunction

    function automatic logic [31:0] bus_word(logic [29:0] w);
        return bus_mem.exists(w) ? bus_mem[w] : seed_word(w);
    endfunction

    function automatic logic [31:0] ref_word(logic [29:0] w);
        return ref_mem.exists(w) ? ref_mem[w] : seed_word(w);
    endfunction

    function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
        return r;
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Processor request: held until accepted, sampled away from the edge
    task automatic access(input bit wr, input bit unc, input logic [31:0] a,
                          input logic [3:0] be, input logic [31:0] wd);
        @(negedge clk);
        cpu_req = 1'b1; cpu_wr = wr; cpu_unc = unc; cpu_addr = a; cpu_be = be; cpu_wdata = wd;
        r_wait = 0;
        forever begin
            #1;
            if (cpu_ready) begin
                r_data = cpu_rdata;
                r_err  = cpu_err;
                @(posedge clk);
                #1 cpu_req = 1'b0;
                break;
            end
            r_wait++;
            @(negedge clk);
        end
        if (wr) begin
            wb_entry_t e;
            e.addr = a; e.data = wd; e.be = be;
            exp_q.push_back(e);
            ref_mem[a[31:2]] = merge(ref_word(a[31:2]), wd, be);
        end
    endtask

    task automatic read_chk(input logic [31:0] a, input bit unc, input string req);
        access(1'b0, unc, a, 4'h0, 32'h0);
        check(r_err == 1'b0, req, "read error flag", 32'(r_err), 32'h0);
        check(r_data == ref_word(a[31:2]), req, "read data", r_data, ref_word(a[31:2]));
    endtask

    task automatic drain();
        pop_en = 1'b1;
        while (wb_rok) @(negedge clk);
        @(negedge clk);
    endtask

    // Bus server: line or word fetch after a short latency, error for 0xE region
    initial begin
        forever begin
            @(negedge clk);
            if (rd_req) begin
                logic [31:0] a;
                bit ln;
                a  = rd_addr;
                ln = rd_line;
                last_fetch_addr = a;
                last_fetch_line = ln;
                repeat (2) @(negedge clk);
                for (int i = 0; i < (ln ? 4 : 1); i++) begin
                    rsp_word = 1'b1;
                    rsp_data = bus_word(a[31:2] + 30'(i));
                    @(negedge clk);
                end
                rsp_word = 1'b0;
                rsp_done = 1'b1;
                rsp_err  = (a[31:28] == 4'hE);
                @(negedge clk);
                rsp_done = 1'b0;
                rsp_err  = 1'b0;
                if (ln) line_fetches++;
                else    word_fetches++;
            end
        end
    end

    // FIFO drain side and drain-order monitor
    initial begin
        forever begin
            @(negedge clk);
            wb_pop = 1'b0;
            if (rd_req && wb_rok) drain_viol++;
            if (pop_en && wb_rok && ($urandom % 2 == 0)) begin
                wb_entry_t e;
                wb_pop = 1'b1;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected FIFO entry", wb_addr, 32'h0);
                end else begin
                    e = exp_q.pop_front();
                    // R7 order and content of posted stores
                    check(wb_addr == e.addr, "R7", "posted address", wb_addr, e.addr);
                    check(wb_data == e.data && wb_be == e.be, "R7", "posted data/be",
                          {wb_data[27:0], wb_be}, {e.data[27:0], e.be});
                end
                bus_mem[wb_addr[31:2]] = merge(bus_word(wb_addr[31:2]), wb_data, wb_be);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int lf, wf;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rd_req == 1'b0, "R1", "rd_req after reset", 32'(rd_req), 32'h0);
        check(wb_rok == 1'b0, "R1", "wb_rok after reset", 32'(wb_rok), 32'h0);
        check(cpu_ready == 1'b0, "R1", "cpu_ready idle", 32'(cpu_ready), 32'h0);

        // R3 first read misses (all lines invalid), line fetch aligned
        lf = line_fetches;
        read_chk(32'h0000_0104, 1'b0, "R3");
        check(line_fetches == lf + 1, "R3", "line fetches", 32'(line_fetches), 32'(lf + 1));
        check(last_fetch_addr == 32'h0000_0100 && last_fetch_line, "R3", "fetch addr",
              last_fetch_addr, 32'h0000_0100);
        check(r_wait > 0, "R1", "miss after reset stalls", 32'(r_wait), 32'h1);

        // R2 hit in same line: zero wait, no fetch
        read_chk(32'h0000_010C, 1'b0, "R2");
        check(r_wait == 0, "R2", "hit wait cycles", 32'(r_wait), 32'h0);
        check(line_fetches == lf + 1, "R2", "no fetch on hit", 32'(line_fetches), 32'(lf + 1));

        // R4 conflict on index 0
        read_chk(32'h0000_0184, 1'b0, "R4");
        read_chk(32'h0000_0108, 1'b0, "R4");
        check(line_fetches == lf + 3, "R4", "conflict refetches", 32'(line_fetches), 32'(lf + 3));

        // R5 uncached reads do not allocate
        wf = word_fetches;
        read_chk(32'h8000_0016, 1'b1, "R5");
        check(last_fetch_addr == 32'h8000_0014 && !last_fetch_line, "R5", "word fetch addr",
              last_fetch_addr, 32'h8000_0014);
        read_chk(32'h8000_0014, 1'b1, "R5");
        check(word_fetches == wf + 2, "R5", "word fetches", 32'(word_fetches), 32'(wf + 2));

        // R6 bus errors, no allocation
        lf = line_fetches;
        access(1'b0, 1'b0, 32'hE000_0020, 4'h0, 32'h0);
        check(r_err == 1'b1, "R6", "line fetch error", 32'(r_err), 32'h1);
        access(1'b0, 1'b0, 32'hE000_0024, 4'h0, 32'h0);
        check(r_err == 1'b1 && line_fetches == lf + 2, "R6", "error not allocated",
              32'(line_fetches), 32'(lf + 2));
        access(1'b0, 1'b1, 32'hE000_0040, 4'h0, 32'h0);
        check(r_err == 1'b1, "R6", "uncached error", 32'(r_err), 32'h1);

        // R8 byte-lane store hit, read back without refill
        pop_en = 1'b1;
        lf = line_fetches;
        access(1'b1, 1'b0, 32'h0000_0108, 4'b0101, 32'hA1B2_C3D4);
        read_chk(32'h0000_0108, 1'b0, "R8");
        check(line_fetches == lf, "R8", "no refill after store hit", 32'(line_fetches), 32'(lf));

        // R7 store miss does not allocate
        access(1'b1, 1'b0, 32'h0000_0300, 4'hF, 32'h0BAD_F00D);
        read_chk(32'h0000_0300, 1'b0, "R7");
        check(line_fetches == lf + 1, "R7", "store miss not allocated", 32'(line_fetches), 32'(lf + 1));

        // R9 back-to-back stores, fifth waits for a pop
        drain();
        pop_en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            access(1'b1, 1'b0, 32'h0000_0600 + 32'(4 * i), 4'hF, 32'h5500_0000 + 32'(i));
            check(r_wait == 0, "R9", "streamed store wait", 32'(r_wait), 32'h0);
        end
        fork
            access(1'b1, 1'b0, 32'h0000_0610, 4'hF, 32'h5500_0004);
            begin
                repeat (6) @(negedge clk);
                #2 check(wb_rok == 1'b1, "R11", "rok while entries held", 32'(wb_rok), 32'h1);
                pop_en = 1'b1;
            end
        join
        check(r_wait >= 6, "R9", "fifth store waited", 32'(r_wait), 32'h6);

        // R10 read miss waits for drain
        drain();
        check(wb_rok == 1'b0, "R11", "rok low when empty", 32'(wb_rok), 32'h0);
        pop_en = 1'b0;
        access(1'b1, 1'b0, 32'h0000_0700, 4'hF, 32'h7777_0000);
        fork
            read_chk(32'h0000_0704, 1'b0, "R10");
            begin
                repeat (8) @(negedge clk);
                pop_en = 1'b1;
            end
        join
        check(r_wait >= 8, "R10", "read waited for drain", 32'(r_wait), 32'h8);

        // Random mix
        for (int n = 0; n < 600; n++) begin
            logic [31:0] a;
            bit wr, unc;
            logic [3:0] be;
            a   = 32'h0000_1000 | (32'($urandom % 3) << 7) | (32'($urandom % 8) << 4)
                | (32'($urandom % 4) << 2);
            unc = ($urandom % 10 == 0);
            if (unc) a = a | 32'h8000_0000;
            wr  = ($urandom % 10 < 4);
            be  = 4'($urandom % 15 + 1);
            if (wr) access(1'b1, unc, a, be, $urandom);
            else    read_chk(a, unc, unc ? "R5" : "R3");
        end

        drain();
        check(exp_q.size() == 0, "R7", "all stores drained", 32'(exp_q.size()), 32'h0);
        check(drain_viol == 0, "R10", "fetch with FIFO non-empty", 32'(drain_viol), 32'h0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule